// File: doc/BRIEF.md
# Key-Sequence Erase-Request Guard

This block is a small memory-mapped configuration slave. It protects a single erase-request control bit from stray software writes. A register bus with address, write data, write enable, read enable and read data reaches two registers: a write-only key register and a control/status register (CSR). The CSR holds the protected erase bit, a busy flag and the current unlock status.

Software unlocks the guard by writing two fixed key bytes in order. It then makes one CSR write, which may request an erase. After that write the guard locks again without further action. An accepted erase request sets the erase bit and the busy flag. It also sends a single-cycle request pulse to an external erase engine. The engine's done input clears both flags.

Top module: `keylock_erase_guard`

## Requirements
- R1: After reset the guard is locked, the CSR reads 0 and `erase_req_o` is low.
- R2: The key register is at byte offset 0x024. Only `wdata_i[7:0]` form the key, and bits 31:8 are ignored. A read of this offset returns 0.
- R3: A key write of 0xCA followed by a key write of 0x53, with no other key write between them, unlocks the guard. CSR bit 2 then reads 1.
- R4: A key write with a value other than the expected next key relocks the guard. The sequence must then start again from 0xCA.
- R5: A key write of 0xCA while the guard waits for the second key keeps it in the first-key-received state. A following 0x53 still unlocks.
- R6: While unlocked, exactly one CSR write is accepted, whatever its data. The guard is locked again in the cycle after that write.
- R7: A CSR write while locked leaves the erase bit and busy flag unchanged and raises no request.
- R8: An accepted CSR write with `wdata_i[0]`=1 while not busy has three effects. CSR bit 0 (erase) and bit 1 (busy) read 1 from the next cycle on. `erase_req_o` is high for exactly that one cycle.
- R9: While busy, a further accepted erase write raises no new request. `erase_done_i` clears the erase and busy bits in the next cycle.
- R10: The CSR is at byte offset 0x018, with erase in bit 0, busy in bit 1 and unlocked in bit 2, and all other bits 0. Writes to other offsets have no effect. Reads of other offsets, or with `re_i` low, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 12 | Byte address of the register access |
| wdata_i | input | 32 | Write data |
| we_i | input | 1 | Write enable, one access per cycle |
| re_i | input | 1 | Read enable |
| rdata_o | output | 32 | Read data, combinational from the current state |
| erase_req_o | output | 1 | Single-cycle erase request to the erase engine |
| erase_done_i | input | 1 | Erase completion from the erase engine |

## Verification
The assertions watch properties of every cycle. The request pulse lasts a single cycle and only follows an accepted set. Unlock is reached only through a second-key write. Every accepted CSR write relocks the guard. A wrong key forces the locked state. A locked CSR write leaves the erase flag alone. Some properties need the bench's ordered scenarios instead. These are the full key order, 0xCA repeated in the middle of the sequence, a wrong key followed by a lone 0x53, reserved key bits, aliasing through unmapped offsets, and a write while busy. A behavioural model checks the request and every read on each clock.

// File: rtl/keylock_pkg.sv
package keylock_pkg;
  typedef enum logic [1:0] {
    KS_LOCKED = 2'd0,
    KS_FIRST  = 2'd1,
    KS_OPEN   = 2'd2
  } key_state_e;

  localparam int unsigned DATA_W      = 32;
  localparam int unsigned CSR_ERASE_B = 0;
  localparam int unsigned CSR_BUSY_B  = 1;
  localparam int unsigned CSR_OPEN_B  = 2;
endpackage

// File: rtl/keylock_decode.sv
module keylock_decode #(
  parameter int unsigned           ADDR_W  = 12,
  parameter logic [ADDR_W-1:0]     KEY_OFF = 12'h024,
  parameter logic [ADDR_W-1:0]     CSR_OFF = 12'h018
) (
  input  logic [ADDR_W-1:0]               addr_i,
  input  logic                            we_i,
  input  logic                            re_i,
  input  logic                            erase_i,
  input  logic                            busy_i,
  input  logic                            open_i,
  output logic                            key_we_o,
  output logic                            csr_we_o,
  output logic [keylock_pkg::DATA_W-1:0]  rdata_o
);
  import keylock_pkg::*;

  logic hit_key, hit_csr;
  logic [DATA_W-1:0] csr_word;

  assign hit_key  = (addr_i == KEY_OFF);
  assign hit_csr  = (addr_i == CSR_OFF);
  assign key_we_o = we_i & hit_key;
  assign csr_we_o = we_i & hit_csr;

  always_comb begin
    csr_word              = '0;
    csr_word[CSR_ERASE_B] = erase_i;
    csr_word[CSR_BUSY_B]  = busy_i;
    csr_word[CSR_OPEN_B]  = open_i;
  end

  // key register is write-only
  always_comb begin
    rdata_o = '0;
    if (re_i && hit_csr) rdata_o = csr_word;
  end
endmodule

// File: rtl/keylock_seq.sv
module keylock_seq #(
  parameter int unsigned        KEY_W   = 8,
  parameter logic [KEY_W-1:0]   KEY_A   = 8'hCA,
  parameter logic [KEY_W-1:0]   KEY_B   = 8'h53
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             key_we_i,
  input  logic [KEY_W-1:0] key_i,
  input  logic             csr_we_i,
  output logic             open_o,
  output logic             accept_o
);
  import keylock_pkg::*;

  key_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (key_we_i) begin
      unique case (state_q)
        KS_FIRST: state_d = (key_i == KEY_B) ? KS_OPEN :
                            (key_i == KEY_A) ? KS_FIRST : KS_LOCKED;
        default:  state_d = (key_i == KEY_A) ? KS_FIRST : KS_LOCKED;
      endcase
    end else if (csr_we_i && state_q == KS_OPEN) begin
      state_d = KS_LOCKED; // one write consumes the unlock
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= KS_LOCKED;
    else         state_q <= state_d;
  end

  assign open_o   = (state_q == KS_OPEN);
  assign accept_o = csr_we_i & open_o;

  // R3
  open_from_key_b_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(open_o) |-> $past(key_we_i && key_i == KEY_B && state_q == KS_FIRST));
  // R4
  wrong_key_locks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_we_i && key_i != KEY_A && !(key_i == KEY_B && state_q == KS_FIRST))
      |=> (state_q == KS_LOCKED));
  // R6
  accept_relocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> !open_o);
  // R5
  repeat_first_key_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_we_i && key_i == KEY_A) |=> (state_q == KS_FIRST));
endmodule

// File: rtl/keylock_erase.sv
module keylock_erase (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic done_i,
  output logic pend_o,
  output logic req_o
);
  logic pend_q, req_q, fire;

  assign fire = set_i & ~pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      req_q <= fire;
      if (pend_q && done_i) pend_q <= 1'b0;
      else if (fire)        pend_q <= 1'b1;
    end
  end

  assign pend_o = pend_q;
  assign req_o  = req_q;

  // R8
  req_single_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |=> !req_o);
  // R8
  req_after_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> ($past(set_i) && pend_o));
  // R9
  done_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o && done_i) |=> !pend_o);
  // R9
  no_req_when_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_o |=> !req_o);
endmodule

// File: rtl/keylock_erase_guard.sv
module keylock_erase_guard #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned KEY_W  = 8
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [ADDR_W-1:0]               addr_i,
  input  logic [keylock_pkg::DATA_W-1:0]  wdata_i,
  input  logic                            we_i,
  input  logic                            re_i,
  output logic [keylock_pkg::DATA_W-1:0]  rdata_o,
  output logic                            erase_req_o,
  input  logic                            erase_done_i
);
  import keylock_pkg::*;

  localparam logic [ADDR_W-1:0] KEY_OFF = ADDR_W'('h024);
  localparam logic [ADDR_W-1:0] CSR_OFF = ADDR_W'('h018);
  localparam logic [KEY_W-1:0]  KEY_A   = KEY_W'('hCA);
  localparam logic [KEY_W-1:0]  KEY_B   = KEY_W'('h53);

  logic key_we, csr_we, open_st, accept, pend;
  logic unused_wdata;

  assign unused_wdata = ^wdata_i[DATA_W-1:KEY_W];

  keylock_decode #(
    .ADDR_W (ADDR_W),
    .KEY_OFF(KEY_OFF),
    .CSR_OFF(CSR_OFF)
  ) u_decode (
    .addr_i  (addr_i),
    .we_i    (we_i),
    .re_i    (re_i),
    .erase_i (pend),
    .busy_i  (pend),
    .open_i  (open_st),
    .key_we_o(key_we),
    .csr_we_o(csr_we),
    .rdata_o (rdata_o)
  );

  keylock_seq #(
    .KEY_W(KEY_W),
    .KEY_A(KEY_A),
    .KEY_B(KEY_B)
  ) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .key_we_i(key_we),
    .key_i   (wdata_i[KEY_W-1:0]),
    .csr_we_i(csr_we),
    .open_o  (open_st),
    .accept_o(accept)
  );

  keylock_erase u_erase (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (accept & wdata_i[CSR_ERASE_B]),
    .done_i(erase_done_i),
    .pend_o(pend),
    .req_o (erase_req_o)
  );

  // R7
  locked_write_inert_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == CSR_OFF && !open_st && !erase_done_i) |=> ($stable(pend) && !erase_req_o));
  // R10
  unmapped_write_inert_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i != CSR_OFF && addr_i != KEY_OFF && !erase_done_i)
      |=> ($stable(pend) && $stable(open_st)));
endmodule

// File: tb/keylock_erase_guard_tb.sv
`timescale 1ns/1ps
module keylock_erase_guard_tb;
  localparam logic [11:0] KEY_A = 12'h024;
  localparam logic [11:0] CSR_A = 12'h018;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic        we = 1'b0, re = 1'b0, done = 1'b0;
  logic [31:0] rdata;
  logic        req;

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  // behavioural model: 0 locked, 1 first key seen, 2 open
  int m_st = 0;
  bit m_pend = 1'b0, m_req = 1'b0;

  always #5 clk = ~clk;

  keylock_erase_guard u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .wdata_i(wdata),
    .we_i(we), .re_i(re), .rdata_o(rdata), .erase_req_o(req),
    .erase_done_i(done)
  );

  function automatic logic [31:0] m_read(input logic [11:0] a);
    if (a == CSR_A) return {29'd0, m_st == 2, m_pend, m_pend};
    return 32'd0;
  endfunction

  always @(posedge clk) begin
    if (rst_ni) begin
      bit nreq;
      bit npend;
      int nst;
      nreq = 1'b0; npend = m_pend; nst = m_st;
      if (we && addr == KEY_A) begin
        if (m_st == 1 && wdata[7:0] == 8'h53) nst = 2;
        else if (wdata[7:0] == 8'hCA) nst = 1;
        else nst = 0;
      end else if (we && addr == CSR_A && m_st == 2) begin
        nst = 0;
        if (wdata[0] && !m_pend) begin npend = 1'b1; nreq = 1'b1; end
      end
      if (done && m_pend) npend = 1'b0;
      m_st = nst; m_pend = npend; m_req = nreq;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle model comparison
  always @(negedge clk) begin
    #4;
    if (rst_ni && !finished) begin
      check(req == m_req, "MODEL req R8", {31'd0, req}, {31'd0, m_req});
      if (re) check(rdata == m_read(addr), "MODEL read R10", rdata, m_read(addr));
      else    check(rdata == 32'd0, "MODEL idle read R10", rdata, 32'd0);
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); addr = a; re = 1'b1;
    #3 check(rdata == exp, tag, rdata, exp);
    @(negedge clk); re = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk); done = 1'b1;
    @(negedge clk); done = 1'b0;
  endtask

  initial begin
    #200000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 check(req == 1'b0, "R1 req low in reset", {31'd0, req}, 32'd0);
    rst_ni = 1'b1;
    rd(CSR_A, 32'd0, "R1 CSR after reset");

    // R2 key register reads zero
    wr(KEY_A, 32'h0000_00CA);
    rd(KEY_A, 32'd0, "R2 key reads zero");
    wr(KEY_A, 32'h0000_0000);

    // R7 locked write inert
    wr(CSR_A, 32'h1);
    #1 check(req == 1'b0, "R7 no req while locked", {31'd0, req}, 32'd0);
    rd(CSR_A, 32'd0, "R7 erase unchanged while locked");

    // R3 unlock
    wr(KEY_A, 32'hCA); wr(KEY_A, 32'h53);
    rd(CSR_A, 32'h4, "R3 unlocked after CA,53");

    // R6 write of zero consumes unlock
    wr(CSR_A, 32'h0);
    #1 check(req == 1'b0, "R6 no req on zero write", {31'd0, req}, 32'd0);
    rd(CSR_A, 32'h0, "R6 relocked after one write");

    // R4 wrong key restarts
    wr(KEY_A, 32'hCA); wr(KEY_A, 32'h12); wr(KEY_A, 32'h53);
    rd(CSR_A, 32'h0, "R4 wrong key relocks");

    // R5 repeated first key
    wr(KEY_A, 32'hCA); wr(KEY_A, 32'hCA); wr(KEY_A, 32'h53);
    rd(CSR_A, 32'h4, "R5 CA,CA,53 unlocks");

    // R8 erase request
    wr(CSR_A, 32'h1);
    #1 check(req == 1'b1, "R8 req pulse high", {31'd0, req}, 32'd1);
    @(negedge clk);
    #1 check(req == 1'b0, "R8 req single cycle", {31'd0, req}, 32'd0);
    rd(CSR_A, 32'h3, "R8 erase and busy set, relocked");

    // R9 set while busy
    wr(KEY_A, 32'hCA); wr(KEY_A, 32'h53);
    wr(CSR_A, 32'h1);
    #1 check(req == 1'b0, "R9 no req while busy", {31'd0, req}, 32'd0);
    rd(CSR_A, 32'h3, "R9 busy kept, write consumed unlock");
    pulse_done();
    rd(CSR_A, 32'h0, "R9 done clears erase and busy");

    // R10 unmapped offsets
    rd(12'h020, 32'd0, "R10 unmapped read zero");
    wr(12'h028, 32'hCA); wr(KEY_A, 32'h53);
    rd(CSR_A, 32'h0, "R10 unmapped key write ignored");
    wr(KEY_A, 32'hCA); wr(12'h01C, 32'h0); wr(KEY_A, 32'h53);
    rd(CSR_A, 32'h4, "R10 unmapped write keeps sequence");
    wr(12'h000, 32'h1);
    rd(CSR_A, 32'h4, "R10 unmapped write does not consume");
    wr(CSR_A, 32'h0);

    // R2 reserved bits ignored
    wr(KEY_A, 32'hABCD_EFCA); wr(KEY_A, 32'h1234_5653);
    rd(CSR_A, 32'h4, "R2 reserved key bits ignored");
    wr(CSR_A, 32'hFFFF_FFF1);
    #1 check(req == 1'b1, "R8 req with upper bits set", {31'd0, req}, 32'd1);
    pulse_done();
    rd(CSR_A, 32'h0, "R9 second done clears");

    // R4 wrong key after unlock relocks
    wr(KEY_A, 32'hCA); wr(KEY_A, 32'h53); wr(KEY_A, 32'h00);
    wr(CSR_A, 32'h1);
    #1 check(req == 1'b0, "R4 wrong key after open relocks", {31'd0, req}, 32'd0);
    rd(CSR_A, 32'h0, "R4 CSR locked");

    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule